// File: doc/BRIEF.md
# Serial Word-RAM Command Port

This block is the device side of a three-wire serial link with a chip select, a static serial clock, a data input and a data output with its own enable. It owns a small word RAM (16 words of 16 bits by default). A host selects the block, clocks in an 8-bit command and then either sends one word, receives one word, or stops after the command. Four command types do not move data. They each produce a one-cycle strobe for a separate protection controller. That controller returns a write-permission level that gates every RAM write made over the serial link.

The serial clock is never used as a clock. It is oversampled by the system clock through a short synchronizer, and its rising and falling edges are detected as single-cycle events. A parallel load port replaces the whole RAM in one cycle, for use during a recall. A flat image output shows every word at all times, for use during a store.

Top module: `serial_nvram_port`

## Requirements
- R1: While `sel` is high and no command has started, serial-clock rising edges that sample `sdi` = 0 are ignored. The first sampled 1 is the start bit of a command.
- R2: A command is 8 bits sampled on serial-clock rising edges, most significant bit first. Bit 7 is the start bit (1), bits 6..3 are the word address, and bits 2..0 are the operation code.
- R3: Operation codes 000, 100, 101 and 001 each raise exactly one of `wen_clr_stb`, `wen_set_stb`, `recall_stb` and `store_stb` respectively, for one system-clock cycle. Code 010 raises no strobe and changes no RAM word.
- R4: Code 011 writes the word at the address. The following data bits arrive least significant bit first, and data bit k is stored into bit k of that word on the rising edge that samples it.
- R5: A serial data bit is stored only if `wr_allow` is high on that edge. Otherwise the word keeps its value.
- R6: If `sel` falls before all 16 data bits of a write arrive, the bits already received stay written and the remaining bits of the word are unchanged.
- R7: Data bits after the 16th wrap around to bit 0 of the same word and overwrite it.
- R8: For codes 110 and 111 (command bit 0 is don't-care), `sdo` carries data bit 0 of the addressed word after the falling edge of the 8th serial clock. Bits 1..15 follow, one per subsequent rising edge.
- R9: `sdo_oe` is low except from the 8th falling edge of a read until `sel` falls. It is low after reset and after every deselect.
- R10: After a command that carries no data, further serial bits are ignored until `sel` goes low and high again.
- R11: A cycle with `load_en` high copies `load_data` into every word. Word i is read from and shown on `image` bits [16i+15:16i].
- R12: If `load_en` and a serial data bit land in the same cycle, the serial bit takes its place over the loaded value. All other bits take the loaded values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the link |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Chip select, high to enable the link |
| sclk | input | 1 | Serial clock (static, asynchronous to clk) |
| sdi | input | 1 | Serial data in |
| wr_allow | input | 1 | Write permission from the protection controller |
| load_en | input | 1 | Parallel load of the whole RAM |
| load_data | input | 256 | Parallel load image, word i at bits 16i+15:16i |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for the data-out pad |
| recall_stb | output | 1 | One-cycle recall request |
| store_stb | output | 1 | One-cycle store request |
| wen_set_stb | output | 1 | One-cycle request to set write permission |
| wen_clr_stb | output | 1 | One-cycle request to clear write permission |
| image | output | 256 | All RAM words, word i at bits 16i+15:16i |

## Verification
A parallel load from `load_en` and the storing of a serial data bit can fall in the same system-clock cycle. Both modify the same storage. The bench provokes this during a write by counting system-clock edges from the change on `sclk` and raising `load_en` for exactly the cycle in which the synchronized rising edge acts. It then judges the addressed word bit by bit: the bits received before the load hold the loaded values, the colliding bit and the later bits hold the serial values, and the other words hold the loaded pattern.

// File: rtl/serial_nvram_port.sv
module serial_nvram_port #(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           sel,
  input  logic                           sclk,
  input  logic                           sdi,
  input  logic                           wr_allow,
  input  logic                           load_en,
  input  logic [(1<<ADDR_W)*DATA_W-1:0]  load_data,
  output logic                           sdo,
  output logic                           sdo_oe,
  output logic                           recall_stb,
  output logic                           store_stb,
  output logic                           wen_set_stb,
  output logic                           wen_clr_stb,
  output logic [(1<<ADDR_W)*DATA_W-1:0]  image
);

  localparam int WORDS  = 1 << ADDR_W;
  localparam int BODY_W = ADDR_W + 3;
  localparam int CNT_W  = $clog2(BODY_W + 1);
  localparam int IDX_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  typedef enum logic [2:0] {ST_HUNT, ST_CMD, ST_WR, ST_RDW, ST_RD, ST_DONE} state_t;

  logic [SYNC_STAGES:0]   sk_pipe;
  logic [SYNC_STAGES-1:0] ce_pipe, di_pipe;
  logic                   ce_s, di_s, sk_rise, sk_fall;

  state_t                 state;
  logic [BODY_W-1:0]      body, body_nx;
  logic [CNT_W-1:0]       cnt;
  logic [ADDR_W-1:0]      addr;
  logic [IDX_W-1:0]       bidx, bidx_nx;
  logic                   wr_bit;
  logic [DATA_W-1:0]      mem [WORDS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sk_pipe <= '0;
      ce_pipe <= '0;
      di_pipe <= '0;
    end else begin
      sk_pipe <= {sk_pipe[SYNC_STAGES-1:0], sclk};
      ce_pipe <= {ce_pipe[SYNC_STAGES-2:0], sel};
      di_pipe <= {di_pipe[SYNC_STAGES-2:0], sdi};
    end
  end

  assign ce_s    = ce_pipe[SYNC_STAGES-1];
  assign di_s    = di_pipe[SYNC_STAGES-1];
  assign sk_rise =  sk_pipe[SYNC_STAGES-1] & ~sk_pipe[SYNC_STAGES];
  assign sk_fall = ~sk_pipe[SYNC_STAGES-1] &  sk_pipe[SYNC_STAGES];

  assign body_nx = {body[BODY_W-2:0], di_s};
  assign bidx_nx = (bidx == IDX_W'(DATA_W - 1)) ? '0 : bidx + 1'b1;
  assign wr_bit  = ce_s && sk_rise && (state == ST_WR) && wr_allow;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_HUNT;
      body        <= '0;
      cnt         <= '0;
      addr        <= '0;
      bidx        <= '0;
      sdo         <= 1'b0;
      sdo_oe      <= 1'b0;
      recall_stb  <= 1'b0;
      store_stb   <= 1'b0;
      wen_set_stb <= 1'b0;
      wen_clr_stb <= 1'b0;
    end else begin
      recall_stb  <= 1'b0;
      store_stb   <= 1'b0;
      wen_set_stb <= 1'b0;
      wen_clr_stb <= 1'b0;
      if (!ce_s) begin
        state  <= ST_HUNT;
        cnt    <= '0;
        sdo_oe <= 1'b0;
      end else begin
        case (state)
          ST_HUNT: if (sk_rise && di_s) begin
            state <= ST_CMD;
            cnt   <= '0;
          end
          ST_CMD: if (sk_rise) begin
            body <= body_nx;
            cnt  <= cnt + 1'b1;
            if (cnt == CNT_W'(BODY_W - 1)) begin
              addr  <= body_nx[BODY_W-1:3];
              bidx  <= '0;
              state <= ST_DONE;
              casez (body_nx[2:0])
                3'b11?: state <= ST_RDW;
                3'b011: state <= ST_WR;
                3'b000: wen_clr_stb <= 1'b1;
                3'b001: store_stb   <= 1'b1;
                3'b100: wen_set_stb <= 1'b1;
                3'b101: recall_stb  <= 1'b1;
                default: ;
              endcase
            end
          end
          ST_WR: if (sk_rise) bidx <= bidx_nx;
          ST_RDW: if (sk_fall) begin
            sdo    <= mem[addr][0];
            sdo_oe <= 1'b1;
            bidx   <= (DATA_W > 1) ? IDX_W'(1) : '0;
            state  <= ST_RD;
          end
          ST_RD: if (sk_rise) begin
            sdo  <= mem[addr][bidx];
            bidx <= bidx_nx;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else begin
      if (load_en)
        for (int i = 0; i < WORDS; i++) mem[i] <= load_data[i*DATA_W +: DATA_W];
      if (wr_bit) mem[addr][bidx] <= di_s;
    end
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_image
    assign image[g*DATA_W +: DATA_W] = mem[g];
  end

endmodule

// File: rtl/serial_nvram_port_chk.sv
module serial_nvram_port_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          ce_s,
  input logic                          sk_rise,
  input logic                          sk_fall,
  input logic                          sdo,
  input logic                          sdo_oe,
  input logic [3:0]                    stb,
  input logic                          wr_allow,
  input logic                          load_en,
  input logic [(1<<ADDR_W)*DATA_W-1:0] image
);

  p_stb_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stb));

  p_stb_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stb != 4'b0) |=> (stb == 4'b0));

  p_oe_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_s |=> !sdo_oe);

  p_sdo_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && $past(sdo_oe) && !$past(sk_rise) && !$past(sk_fall)) |-> $stable(sdo));

  p_guarded_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(load_en) && (image != $past(image))) |-> $past(wr_allow));

endmodule

bind serial_nvram_port serial_nvram_port_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .ce_s     (ce_s),
  .sk_rise  (sk_rise),
  .sk_fall  (sk_fall),
  .sdo      (sdo),
  .sdo_oe   (sdo_oe),
  .stb      ({recall_stb, store_stb, wen_set_stb, wen_clr_stb}),
  .wr_allow (wr_allow),
  .load_en  (load_en),
  .image    (image)
);

// File: tb/serial_nvram_port_tb.sv
module serial_nvram_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;
  localparam int WORDS      = 16;

  logic clk = 0, rst_n = 0, sel = 0, sclk = 0, sdi = 0, wr_allow = 0, load_en = 0;
  logic [WORDS*16-1:0] load_data, image;
  logic sdo, sdo_oe, recall_stb, store_stb, wen_set_stb, wen_clr_stb;

  int total = 0, bad = 0;
  int n_rcl = 0, n_sto = 0, n_set = 0, n_clr = 0, n_multi = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_nvram_port dut_i (
    .clk(clk), .rst_n(rst_n), .sel(sel), .sclk(sclk), .sdi(sdi),
    .wr_allow(wr_allow), .load_en(load_en), .load_data(load_data),
    .sdo(sdo), .sdo_oe(sdo_oe), .recall_stb(recall_stb), .store_stb(store_stb),
    .wen_set_stb(wen_set_stb), .wen_clr_stb(wen_clr_stb), .image(image)
  );

  always @(posedge clk) begin
    n_rcl <= n_rcl + int'(recall_stb);
    n_sto <= n_sto + int'(store_stb);
    n_set <= n_set + int'(wen_set_stb);
    n_clr <= n_clr + int'(wen_clr_stb);
    if (recall_stb && $past(recall_stb)) n_multi <= n_multi + 1;
  end

  // addr, wr_allow, data, expected readback
  localparam logic [36:0] VEC [6] = '{
    {4'd3,  1'b1, 16'hA5C3, 16'hA5C3},
    {4'd15, 1'b1, 16'h8001, 16'h8001},
    {4'd3,  1'b0, 16'hFFFF, 16'hA5C3},
    {4'd0,  1'b1, 16'h1234, 16'h1234},
    {4'd15, 1'b1, 16'h0000, 16'h0000},
    {4'd9,  1'b0, 16'hBEEF, 16'h0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clk_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sk_bit(input logic b);
    sdi = b;
    clk_n(2);
    sclk = 1;
    clk_n(HALF);
    sclk = 0;
    clk_n(HALF);
  endtask

  task automatic open_sel;
    sel = 1;
    clk_n(4);
  endtask

  task automatic close_sel;
    sel = 0;
    sdi = 0;
    clk_n(4);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) sk_bit(v[i]);
  endtask

  task automatic write_word(input logic [3:0] a, input logic [31:0] stream, input int nbits);
    open_sel();
    send_byte({1'b1, a, 3'b011});
    for (int i = 0; i < nbits; i++) sk_bit(stream[i]);
    close_sel();
  endtask

  task automatic read_word(input logic [3:0] a, input logic b0, output logic [15:0] w,
                           output logic oe_pre, output logic oe_mid);
    logic [7:0] c;
    c = {1'b1, a, 2'b11, b0};
    open_sel();
    for (int i = 7; i >= 1; i--) sk_bit(c[i]);
    oe_pre = sdo_oe;
    sk_bit(c[0]);
    w[0] = sdo;
    oe_mid = sdo_oe;
    for (int k = 1; k < 16; k++) begin
      sk_bit(1'b0);
      w[k] = sdo;
    end
    close_sel();
  endtask

  task automatic plain_cmd(input logic [2:0] op);
    open_sel();
    send_byte({1'b1, 4'b1010, op});
    close_sel();
  endtask

  function automatic logic [15:0] pat(input int i);
    return 16'(i * 16'h0101 + 16'h5A00);
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    logic oe_a, oe_b;
    int c0, c1, c2, c3, mism;
    logic [WORDS*16-1:0] snap;

    for (int i = 0; i < WORDS; i++) load_data[i*16 +: 16] = pat(i);
    clk_n(5);
    rst_n = 1;
    clk_n(3);

    // reset state (R9, R11)
    chk("R9 reset oe", sdo_oe, 0);
    chk("R3 reset strobes", {recall_stb, store_stb, wen_set_stb, wen_clr_stb}, 0);
    chk("R11 reset image", image[255:0] == '0, 1);

    // vector table: write (R2, R4, R5) then serial read back (R8, R9)
    foreach (VEC[v]) begin
      wr_allow = VEC[v][32];
      write_word(VEC[v][36:33], {16'h0, VEC[v][31:16]}, 16);
      wr_allow = 1;
      chk("R4/R5 image word", image[VEC[v][36:33]*16 +: 16], VEC[v][15:0]);
      read_word(VEC[v][36:33], v[0], w, oe_a, oe_b);
      chk("R8 serial read", w, VEC[v][15:0]);
      chk("R9 oe before 8th fall", oe_a, 0);
      chk("R9 oe during read", oe_b, 1);
      chk("R9 oe after deselect", sdo_oe, 0);
    end

    // R1: leading zeros before the start bit
    open_sel();
    sk_bit(0); sk_bit(0); sk_bit(0);
    send_byte({1'b1, 4'd5, 3'b011});
    for (int i = 0; i < 16; i++) sk_bit(i[3]);
    close_sel();
    chk("R1 leading zeros ignored", image[5*16 +: 16], 16'hFF00);

    // R3: non-data commands and their strobes
    snap = image;
    c0 = n_clr; c1 = n_sto; c2 = n_set; c3 = n_rcl;
    plain_cmd(3'b000);
    plain_cmd(3'b001);
    plain_cmd(3'b100);
    plain_cmd(3'b101);
    plain_cmd(3'b010);
    chk("R3 clear strobe count", n_clr - c0, 1);
    chk("R3 store strobe count", n_sto - c1, 1);
    chk("R3 set strobe count", n_set - c2, 1);
    chk("R3 recall strobe count", n_rcl - c3, 1);
    chk("R3 recall pulse width", n_multi, 0);
    chk("R3 reserved leaves RAM", image == snap, 1);

    // R6: short write keeps received bits, rest unchanged
    write_word(4'd5, 32'h0000_00FF, 10);
    chk("R6 partial write", image[5*16 +: 16], 16'hFCFF);

    // R7: more than 16 bits wrap and overwrite
    write_word(4'd6, 32'h000F_1234, 20);
    chk("R7 wrap overwrite", image[6*16 +: 16], 16'h123F);

    // R10: bits after a non-data command are ignored until reselect
    c2 = n_set;
    open_sel();
    send_byte({1'b1, 4'd0, 3'b100});
    send_byte({1'b1, 4'd7, 3'b011});
    for (int i = 0; i < 16; i++) sk_bit(1'b1);
    close_sel();
    chk("R10 trailing bits ignored", image[7*16 +: 16], 16'h0000);
    chk("R10 one strobe only", n_set - c2, 1);

    // R11: parallel load of every word
    load_en = 1;
    clk_n(1);
    load_en = 0;
    clk_n(1);
    mism = 0;
    for (int i = 0; i < WORDS; i++) if (image[i*16 +: 16] !== pat(i)) mism++;
    chk("R11 load mismatches", mism, 0);
    read_word(4'd2, 1'b0, w, oe_a, oe_b);
    chk("R11 loaded word via link", w, pat(2));

    // R12: load collides with serial data bit 3
    open_sel();
    send_byte({1'b1, 4'd1, 3'b011});
    for (int i = 0; i < 16; i++) begin
      if (i == 3) begin
        sdi = 1;
        clk_n(2);
        sclk = 1;
        clk_n(2);
        load_en = 1;
        clk_n(1);
        load_en = 0;
        clk_n(HALF - 3);
        sclk = 0;
        clk_n(HALF);
      end else sk_bit(1'b1);
    end
    close_sel();
    chk("R12 collided word", image[1*16 +: 16], 16'hFFF9);
    chk("R12 other word loaded", image[2*16 +: 16], pat(2));
    chk("R12 written word 0 reloaded", image[0 +: 16], pat(0));

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule